// File: doc/BRIEF.md
# Comma Alignment and Delay Counter

This receive-side block sits behind a deserialiser that delivers ten line bits per clock with no knowledge of where symbols begin. It keeps the previous word next to the current one. It searches that 20-bit window for the seven-bit comma in either polarity and fixes a barrel-shift offset on the first hit. From then on it emits one aligned ten-bit symbol per clock, sorted into the alignment, sync, skip and error special codes or "none".

The first alignment symbol seen after lock is treated as a time mark. The block raises a synchronisation acknowledge on it, and from that mark it counts unit intervals (ten per symbol) and alignment symbols. The two counts give a propagation-delay estimate relative to the master transmitter. A restart input zeroes both counts without disturbing lock.

The controller has three states. HUNT means no lock. ALIGNED means locked and waiting for the mark. TIMING means the acknowledge is held and the counters are running. The transitions are:
- FOUND: HUNT to ALIGNED, when a comma is seen.
- MARK: ALIGNED to TIMING, on the first alignment symbol.
- DROP: ALIGNED or TIMING to HUNT, on an error symbol or on a run of unknown symbols.

Top module: `symsync_delay_top`

## Requirements
- R1: Bit 9 of `rx_word` is the earliest bit on the line, and the window is {previous word, current word}. In HUNT, when 0011111 or 1100000 starts at window bit 19-o for some o in 0..9, the next edge sets `locked`=1 and `align_off`=o. The lowest such o wins. While locked, the offset does not change.
- R2: While locked, the block produces one symbol per clock with `sym_vld`=1 and `sym_kind` coded as follows: 0 none, 1 A=0011110011, 2 K=0011111010, 3 R=0011110100, 4 E=0111101000. The bitwise complement of each code decodes to the same kind. A symbol is reported at the edge that follows the word carrying its last bit.
- R3: `sync_ack` rises together with the report of the first A after lock (transition MARK). It then stays high while lock holds.
- R4: An E while locked clears `locked` and `sync_ack` at the edge that reports it (transition DROP). That edge still reports kind 4.
- R5: LOSS_LIMIT consecutive "none" symbols cause DROP at the edge that reports the last of them. Any valid symbol restarts the run.
- R6: At MARK, `ui_count` and `a_count` become 0. Each later symbol reported in TIMING without a DROP adds 10 to `ui_count`, and adds 1 to `a_count` if it is an A.
- R7: Both counters saturate at their all-ones value.
- R8: `cnt_clear` zeroes both counters at the next edge, with priority over counting. It leaves lock and the acknowledge untouched.
- R9: After DROP, both counters hold their values until `cnt_clear` or the next MARK.
- R10: After reset, `locked`, `sync_ack`, `sym_vld`, `sym_kind`, `align_off` and both counters are 0.
- R11: In HUNT, `sym_vld` is 0 at the following edge, and no acknowledge is given without lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 10 | Unaligned word from the deserialiser, bit 9 earliest |
| cnt_clear | input | 1 | Restart: zero the UI and A counters |
| locked | output | 1 | Symbol alignment held (ALIGNED or TIMING) |
| sync_ack | output | 1 | Synchronisation acknowledge (TIMING) |
| align_off | output | 4 | Locked barrel-shift offset, 0..9 |
| sym_vld | output | 1 | A classified symbol is reported this cycle |
| sym_kind | output | 3 | Kind of the reported symbol |
| ui_count | output | UI_W (16) | Unit intervals since the mark |
| a_count | output | A_W (8) | Alignment symbols since the mark |

## Verification
The bench builds the block with its defaults: LOSS_LIMIT of 4, a 16-bit UI counter and an 8-bit A counter. With these widths, saturation of both counters is reached within a few thousand symbols of a steady alignment stream. The loss run is short enough to probe both its reset and its limit. Every bit slip from 0 to 9 is driven in both comma polarities, so each barrel-shift path and the offset priority are exercised.

// File: rtl/symsync_pkg.sv
package symsync_pkg;
    localparam int SYM_W   = 10;
    localparam int COMMA_W = 7;
    localparam int OFF_W   = $clog2(SYM_W);

    // comma in its positive running-disparity form; the negative form is its complement
    localparam logic [COMMA_W-1:0] COMMA_POS = 7'b0011111;

    localparam logic [SYM_W-1:0] CODE_ALN  = 10'b0011110011;
    localparam logic [SYM_W-1:0] CODE_SYNC = 10'b0011111010;
    localparam logic [SYM_W-1:0] CODE_SKIP = 10'b0011110100;
    localparam logic [SYM_W-1:0] CODE_ERR  = 10'b0111101000;

    typedef enum logic [2:0] {
        SK_NONE = 3'd0,
        SK_A    = 3'd1,
        SK_K    = 3'd2,
        SK_R    = 3'd3,
        SK_E    = 3'd4
    } sym_kind_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_ALIGNED = 2'd1,
        ST_TIMING  = 2'd2
    } sync_state_e;
endpackage

// File: rtl/comma_scan.sv
module comma_scan
    import symsync_pkg::*;
(
    input  logic [2*SYM_W-1:0] window,
    output logic               hit,
    output logic [OFF_W-1:0]   hit_off
);
    logic [SYM_W-1:0] match;

    for (genvar o = 0; o < SYM_W; o++) begin : g_off
        logic [COMMA_W-1:0] slice;
        assign slice    = window[2*SYM_W-1-o -: COMMA_W];
        assign match[o] = (slice == COMMA_POS) || (slice == ~COMMA_POS);
    end

    // lowest offset wins: scan downward so the last assignment is the smallest index
    always_comb begin
        hit     = |match;
        hit_off = '0;
        for (int o = SYM_W - 1; o >= 0; o--) begin
            if (match[o]) begin
                hit_off = OFF_W'(o);
            end
        end
    end
endmodule

// File: rtl/sym_barrel.sv
module sym_barrel
    import symsync_pkg::*;
(
    input  logic [2*SYM_W-1:0] window,
    input  logic [OFF_W-1:0]   off,
    output logic [SYM_W-1:0]   sym
);
    logic [SYM_W-1:0] cand [SYM_W];

    for (genvar o = 0; o < SYM_W; o++) begin : g_tap
        assign cand[o] = window[2*SYM_W-1-o -: SYM_W];
    end

    always_comb begin
        sym = cand[0];
        for (int o = 1; o < SYM_W; o++) begin
            if (off == OFF_W'(o)) begin
                sym = cand[o];
            end
        end
    end
endmodule

// File: rtl/sym_decode.sv
module sym_decode
    import symsync_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_kind_e        kind
);
    always_comb begin
        if (sym == CODE_ALN || sym == ~CODE_ALN) begin
            kind = SK_A;
        end else if (sym == CODE_SYNC || sym == ~CODE_SYNC) begin
            kind = SK_K;
        end else if (sym == CODE_SKIP || sym == ~CODE_SKIP) begin
            kind = SK_R;
        end else if (sym == CODE_ERR || sym == ~CODE_ERR) begin
            kind = SK_E;
        end else begin
            kind = SK_NONE;
        end
    end
endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import symsync_pkg::*;
#(
    parameter int LOSS_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comma_hit,
    input  logic [OFF_W-1:0] comma_off,
    input  sym_kind_e        cur_kind,
    output logic             locked,
    output logic             ack,
    output logic [OFF_W-1:0] off_q,
    output logic             sym_vld,
    output sym_kind_e        sym_kind,
    output logic             cnt_start,
    output logic             cnt_step,
    output logic             cnt_is_a
);
    localparam int              BAD_W    = $clog2(LOSS_LIMIT + 1);
    localparam logic [BAD_W-1:0] BAD_LAST = BAD_W'(LOSS_LIMIT - 1);

    sync_state_e      state_q, state_d;
    logic [BAD_W-1:0] bad_q, bad_d;
    logic [OFF_W-1:0] off_d;
    logic             is_bad, lose;

    // next-state logic
    always_comb begin
        is_bad  = (cur_kind == SK_NONE);
        lose    = (cur_kind == SK_E) || (is_bad && bad_q == BAD_LAST);
        state_d = state_q;
        off_d   = off_q;
        bad_d   = '0;
        unique case (state_q)
            ST_HUNT: begin
                if (comma_hit) begin
                    state_d = ST_ALIGNED;            // FOUND
                    off_d   = comma_off;
                end
            end
            ST_ALIGNED: begin
                if (lose) begin
                    state_d = ST_HUNT;               // DROP
                end else begin
                    if (cur_kind == SK_A) begin
                        state_d = ST_TIMING;         // MARK
                    end
                    bad_d = is_bad ? bad_q + BAD_W'(1) : '0;
                end
            end
            ST_TIMING: begin
                if (lose) begin
                    state_d = ST_HUNT;               // DROP
                end else begin
                    bad_d = is_bad ? bad_q + BAD_W'(1) : '0;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            off_q   <= '0;
            bad_q   <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            bad_q   <= bad_d;
        end
    end

    // registered symbol report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld  <= 1'b0;
            sym_kind <= SK_NONE;
        end else begin
            sym_vld  <= (state_q != ST_HUNT);
            sym_kind <= (state_q != ST_HUNT) ? cur_kind : SK_NONE;
        end
    end

    assign locked    = (state_q != ST_HUNT);
    assign ack       = (state_q == ST_TIMING);
    assign cnt_start = (state_q == ST_ALIGNED) && (state_d == ST_TIMING);
    assign cnt_step  = (state_q == ST_TIMING) && (state_d == ST_TIMING);
    assign cnt_is_a  = (cur_kind == SK_A);

    p_lock_on_comma_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && comma_hit) |=> (locked && off_q == $past(comma_off)));

    p_off_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!locked || $stable(off_q)));

    p_ack_on_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> (sym_kind == SK_A && sym_vld));

    p_e_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cur_kind == SK_E) |=> (!locked && !ack && sym_kind == SK_E));

    p_valid_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cur_kind != SK_NONE && cur_kind != SK_E) |=> locked);

    p_hunt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !sym_vld);
endmodule

// File: rtl/delay_tally.sv
module delay_tally #(
    parameter int UI_W    = 16,
    parameter int A_W     = 8,
    parameter int UI_STEP = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            start,
    input  logic            step,
    input  logic            is_a,
    output logic [UI_W-1:0] ui_q,
    output logic [A_W-1:0]  a_q
);
    localparam logic [UI_W-1:0] UI_MAX = '1;
    localparam logic [A_W-1:0]  A_MAX  = '1;
    localparam logic [UI_W-1:0] STEP_V = UI_W'(UI_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n || clear || start) begin
            ui_q <= '0;
            a_q  <= '0;
        end else if (step) begin
            ui_q <= (ui_q > UI_MAX - STEP_V) ? UI_MAX : ui_q + STEP_V;
            if (is_a && a_q != A_MAX) begin
                a_q <= a_q + A_W'(1);
            end
        end
    end

    p_ui_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !start && ui_q <= UI_MAX - STEP_V) |=> ui_q == $past(ui_q) + STEP_V);

    p_ui_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ui_q == UI_MAX && !clear && !start) |=> ui_q == UI_MAX);

    p_a_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q == A_MAX && !clear && !start) |=> a_q == A_MAX);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ui_q == '0 && a_q == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear && !start) |=> ($stable(ui_q) && $stable(a_q)));
endmodule

// File: rtl/symsync_delay_top.sv
module symsync_delay_top
    import symsync_pkg::*;
#(
    parameter int LOSS_LIMIT = 4,
    parameter int UI_W       = 16,
    parameter int A_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [9:0]       rx_word,
    input  logic             cnt_clear,
    output logic             locked,
    output logic             sync_ack,
    output logic [3:0]       align_off,
    output logic             sym_vld,
    output logic [2:0]       sym_kind,
    output logic [UI_W-1:0]  ui_count,
    output logic [A_W-1:0]   a_count
);
    logic [SYM_W-1:0]   prev_q;
    logic [2*SYM_W-1:0] window;
    logic               comma_hit;
    logic [OFF_W-1:0]   comma_off;
    logic [OFF_W-1:0]   off_q;
    logic [SYM_W-1:0]   aligned;
    sym_kind_e          cur_kind;
    sym_kind_e          kind_q;
    logic               cnt_start, cnt_step, cnt_is_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= rx_word;
        end
    end

    assign window = {prev_q, rx_word};

    comma_scan u_scan (
        .window  (window),
        .hit     (comma_hit),
        .hit_off (comma_off)
    );

    sym_barrel u_barrel (
        .window (window),
        .off    (off_q),
        .sym    (aligned)
    );

    sym_decode u_decode (
        .sym  (aligned),
        .kind (cur_kind)
    );

    sync_fsm #(.LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .comma_hit (comma_hit),
        .comma_off (comma_off),
        .cur_kind  (cur_kind),
        .locked    (locked),
        .ack       (sync_ack),
        .off_q     (off_q),
        .sym_vld   (sym_vld),
        .sym_kind  (kind_q),
        .cnt_start (cnt_start),
        .cnt_step  (cnt_step),
        .cnt_is_a  (cnt_is_a)
    );

    delay_tally #(.UI_W(UI_W), .A_W(A_W), .UI_STEP(SYM_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .start (cnt_start),
        .step  (cnt_step),
        .is_a  (cnt_is_a),
        .ui_q  (ui_count),
        .a_q   (a_count)
    );

    assign sym_kind  = kind_q;
    assign align_off = 4'(off_q);
endmodule

// File: tb/symsync_delay_top_bench.sv
module symsync_delay_top_bench;
    localparam logic [9:0] SA  = 10'b0011110011;
    localparam logic [9:0] SK  = 10'b0011111010;
    localparam logic [9:0] SR  = 10'b0011110100;
    localparam logic [9:0] SE  = 10'b0111101000;
    localparam logic [9:0] SAC = 10'b1100001100;
    localparam logic [9:0] SKC = 10'b1100000101;
    localparam logic [9:0] SRC = 10'b1100001011;
    localparam logic [9:0] SBD = 10'b0101010101;

    // table: symbol sent, then expected outputs after that edge (reports previous symbol)
    localparam logic [9:0] TV_SYM [16] = '{SR, SR, SK, SR, SA, SK, SR, SRC,
                                          SKC, SAC, SR, SBD, SA, SE, SR, SR};
    localparam int TV_VLD  [16] = '{0,0,0,0,1,1,1,1,1,1,1,1,1,1,1,0};
    localparam int TV_KIND [16] = '{0,0,0,0,3,1,2,3,3,2,1,3,0,1,4,0};
    localparam int TV_LOCK [16] = '{0,0,0,1,1,1,1,1,1,1,1,1,1,1,0,0};
    localparam int TV_ACK  [16] = '{0,0,0,0,0,1,1,1,1,1,1,1,1,1,0,0};
    localparam int TV_UI   [16] = '{0,0,0,0,0,0,10,20,30,40,50,60,70,80,80,80};
    localparam int TV_A    [16] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,2,2,2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  rx_word = '0;
    logic        cnt_clear = 1'b0;
    logic        locked, sync_ack, sym_vld;
    logic [3:0]  align_off;
    logic [2:0]  sym_kind;
    logic [15:0] ui_count;
    logic [7:0]  a_count;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [9:0]  prev_sym = '0;
    int          slip = 0;

    always #4 clk = ~clk;

    symsync_delay_top u_symsync_delay_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_word   (rx_word),
        .cnt_clear (cnt_clear),
        .locked    (locked),
        .sync_ack  (sync_ack),
        .align_off (align_off),
        .sym_vld   (sym_vld),
        .sym_kind  (sym_kind),
        .ui_count  (ui_count),
        .a_count   (a_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_sym(input logic [9:0] s, input logic clr);
        logic [19:0] pair;
        pair      = {prev_sym, s} >> slip;
        rx_word   = pair[9:0];
        cnt_clear = clr;
        prev_sym  = s;
        @(negedge clk);
    endtask

    task automatic do_reset(input int s);
        rst_n     = 1'b0;
        rx_word   = '0;
        cnt_clear = 1'b0;
        prev_sym  = '0;
        slip      = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R10: reset state
        chk("R10 locked", int'(locked), 0);
        chk("R10 ack", int'(sync_ack), 0);
        chk("R10 vld", int'(sym_vld), 0);
        chk("R10 kind", int'(sym_kind), 0);
        chk("R10 off", int'(align_off), 0);
        chk("R10 ui", int'(ui_count), 0);
        chk("R10 acnt", int'(a_count), 0);

        // table walk at slip 3 (R1 R2 R3 R4 R6 R9 R11)
        for (int i = 0; i < 16; i++) begin
            put_sym(TV_SYM[i], 1'b0);
            chk($sformatf("R2 vld t%0d", i), int'(sym_vld), TV_VLD[i]);
            chk($sformatf("R2 kind t%0d", i), int'(sym_kind), TV_KIND[i]);
            chk($sformatf("R1/R4 lock t%0d", i), int'(locked), TV_LOCK[i]);
            chk($sformatf("R3 ack t%0d", i), int'(sync_ack), TV_ACK[i]);
            chk($sformatf("R6 ui t%0d", i), int'(ui_count), TV_UI[i]);
            chk($sformatf("R6 acnt t%0d", i), int'(a_count), TV_A[i]);
            if (i == 3) chk("R1 offset slip3", int'(align_off), 3);
        end

        // R1: every slip, both comma polarities
        for (int s = 0; s < 10; s++) begin
            for (int pol = 0; pol < 2; pol++) begin
                do_reset(s);
                put_sym(pol ? SRC : SR, 1'b0);
                put_sym(pol ? SRC : SR, 1'b0);
                put_sym(pol ? SKC : SK, 1'b0);
                chk($sformatf("R1 no early lock s%0d", s), int'(locked), 0);
                put_sym(pol ? SRC : SR, 1'b0);
                chk($sformatf("R1 lock s%0d p%0d", s, pol), int'(locked), 1);
                chk($sformatf("R1 off s%0d p%0d", s, pol), int'(align_off), s);
                put_sym(pol ? SAC : SA, 1'b0);
                chk($sformatf("R2 kind after lock s%0d p%0d", s, pol), int'(sym_kind), 3);
            end
        end

        // R5: invalid run reset by a valid symbol, then loss on the limit
        do_reset(0);
        put_sym(SR, 1'b0); put_sym(SR, 1'b0); put_sym(SK, 1'b0); put_sym(SR, 1'b0);
        put_sym(SBD, 1'b0); put_sym(SBD, 1'b0); put_sym(SBD, 1'b0); put_sym(SR, 1'b0);
        put_sym(SBD, 1'b0);
        chk("R5 run broken keeps lock", int'(locked), 1);
        put_sym(SBD, 1'b0); put_sym(SBD, 1'b0); put_sym(SBD, 1'b0);
        chk("R5 three invalid keep lock", int'(locked), 1);
        put_sym(SR, 1'b0);
        chk("R5 fourth invalid drops", int'(locked), 0);
        chk("R5 reports none", int'(sym_kind), 0);
        chk("R5 reports valid", int'(sym_vld), 1);

        // R6: mark then eight KRRKKRRA frames gives 640 UI and 8 A symbols
        do_reset(0);
        put_sym(SR, 1'b0); put_sym(SR, 1'b0); put_sym(SK, 1'b0); put_sym(SR, 1'b0);
        put_sym(SA, 1'b0);
        for (int f = 0; f < 8; f++) begin
            put_sym(SK, 1'b0);
            if (f == 0) begin
                chk("R3 ack on mark", int'(sync_ack), 1);
                chk("R6 ui zero at mark", int'(ui_count), 0);
            end
            put_sym(SR, 1'b0); put_sym(SR, 1'b0); put_sym(SK, 1'b0);
            put_sym(SK, 1'b0); put_sym(SR, 1'b0); put_sym(SR, 1'b0);
            put_sym(SA, 1'b0);
        end
        put_sym(SR, 1'b0);
        chk("R6 ui after 8 frames", int'(ui_count), 640);
        chk("R6 acnt after 8 frames", int'(a_count), 8);
        chk("R3 ack held", int'(sync_ack), 1);

        // R8: clear has priority and keeps lock/ack
        put_sym(SR, 1'b1);
        chk("R8 ui cleared", int'(ui_count), 0);
        chk("R8 acnt cleared", int'(a_count), 0);
        chk("R8 ack kept", int'(sync_ack), 1);
        chk("R8 lock kept", int'(locked), 1);
        put_sym(SR, 1'b0);
        chk("R8 counting resumes", int'(ui_count), 10);

        // R7: saturation
        for (int n = 0; n < 6600; n++) put_sym(SA, 1'b0);
        chk("R7 ui saturated", int'(ui_count), 65535);
        chk("R7 acnt saturated", int'(a_count), 255);

        // R4 and R9: error drops lock, counters hold
        put_sym(SE, 1'b0);
        put_sym(SR, 1'b0);
        chk("R4 lock dropped", int'(locked), 0);
        chk("R4 ack dropped", int'(sync_ack), 0);
        chk("R4 reports E", int'(sym_kind), 4);
        put_sym(SR, 1'b0);
        put_sym(SR, 1'b0);
        chk("R11 hunt no vld", int'(sym_vld), 0);
        chk("R9 ui held", int'(ui_count), 65535);
        chk("R9 acnt held", int'(a_count), 255);

        // R6: relock and new mark restarts counting
        put_sym(SK, 1'b0);
        put_sym(SR, 1'b0);
        chk("R1 relock", int'(locked), 1);
        put_sym(SA, 1'b0);
        chk("R11 no ack before mark", int'(sync_ack), 0);
        put_sym(SR, 1'b0);
        chk("R3 ack on new mark", int'(sync_ack), 1);
        chk("R6 ui restarted", int'(ui_count), 0);
        chk("R6 acnt restarted", int'(a_count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule